// File: doc/BRIEF.md
# Nibble-Addressed Tile Bank Register File

This block holds the bank selections for a pattern-memory window split into eight 1 KB slots, plus two switchable 8 KB program pages. A CPU writes it with 8-bit data and a 16-bit address. Each slot bank number is put together from two separate 4-bit writes. The address picks both the slot and the half of it that changes. The two program page registers and the mirroring select each take a single write.

The outputs drive the memory address logic directly. There are eight slot bank numbers, each widened by one outer-bank bit taken from an external mode register. There are four program page numbers: two chosen by software, then the second-to-last page and the last page. There is also a single mirroring select. An enable input ties the block to its operating mode: when it is low, every write is dropped.

Top module: `tile_bank_regfile`

## Requirements
- R1: A slot write is accepted only when the address lies in 0xB000..0xE003 inclusive. The slot index is (((addr & 2) | (addr >> 10)) >> 1) + 2, taken mod 8. So 0xB000 reaches slot 0, 0xB002 reaches slot 1, 0xC000 reaches slot 2 and 0xE002 reaches slot 7.
- R2: On a slot write, address bit 0 picks the nibble. With bit 0 = 0, data bits 3:0 replace bank bits 3:0. With bit 0 = 1, data bits 3:0 replace bank bits 7:4. The other nibble keeps its value.
- R3: Outside the slot range, a write with address bits 15:12 = 0x8 loads program page 0 with the full data byte. A write with bits 15:12 = 0xA loads program page 1 with the full data byte.
- R4: Program output 0 is page register 0 and output 1 is page register 1. Output 2 is the second-to-last page (all ones except bit 0). Output 3 is the last page (all ones).
- R5: Outside the slot range, a write with address bits 15:12 = 0x9 stores data bit 0 as the mirroring select. The output mirror_horiz = 1 means horizontal and 0 means vertical.
- R6: Bit 8 of every slot bank output equals the value that outer_sel had at the previous clock edge. Bits 7:0 are the slot register.
- R7: After reset, slots 0 to 3 read 0xFF, slots 4 to 7 read 4, 5, 6 and 7, the program page registers read 0 and 1, mirroring reads 0 and the outer bit reads 0.
- R8: A write changes state only when en and wr_stb are both high at the clock edge. Otherwise all slot, program and mirroring values hold.
- R9: An accepted write becomes visible on the outputs only after the clock edge that samples it, never before.
- R10: Writes to any other address change nothing. This includes 0xE004 to 0xEFFF, 0xF000 to 0xFFFF and everything below 0x8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Operating-mode enable; gates all writes |
| wr_stb | input | 1 | Write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| outer_sel | input | 1 | Outer-bank bit from the external mode register (its bit 2) |
| slot_bank | output | 8x9 | Per-slot bank number, outer bit in bit 8 |
| prg_page | output | 4x8 | Program page number for each 8 KB window |
| mirror_horiz | output | 1 | 1 = horizontal mirroring, 0 = vertical |

## Verification
The bench builds the block with its default widths: 8-bit slot banks, 8-bit program pages and a 16-bit address. This covers all sixteen slot and nibble addresses, along with aliases such as 0xB800 that the index formula folds onto low slots. Full-byte program values, including 0x00 and 0xFF, can be checked exactly against the fixed last pages. A behavioural model driven by the same stimulus follows the enable, strobe, outer bit and out-of-range cases on every cycle. That stimulus covers directed writes and a long randomized run.

// File: rtl/tbr_pkg.sv
package tbr_pkg;

    localparam int SLOT_CNT = 8;
    localparam int IDX_W    = $clog2(SLOT_CNT);
    localparam int PRG_WIN  = 4;

    typedef struct packed {
        logic             slot_hit;
        logic [IDX_W-1:0] slot_idx;
        logic             hi_nib;
        logic             prg0_hit;
        logic             prg1_hit;
        logic             mir_hit;
    } wr_dec_t;

endpackage

// File: rtl/tbr_decode.sv
module tbr_decode
    import tbr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output wr_dec_t           dec
);

    localparam logic [ADDR_W-1:0] SLOT_LO = ADDR_W'('hB000);
    localparam logic [ADDR_W-1:0] SLOT_HI = ADDR_W'('hE003);

    always_comb begin
        dec          = '0;
        dec.slot_hit = (addr >= SLOT_LO) && (addr <= SLOT_HI);
        // index = ({a13, a12, a11 | a1} + 2) mod 8
        dec.slot_idx = {addr[13], addr[12], addr[11] | addr[1]} + IDX_W'(2);
        dec.hi_nib   = addr[0];
        if (!dec.slot_hit) begin
            unique case (addr[15:12])
                4'h8:    dec.prg0_hit = 1'b1;
                4'h9:    dec.mir_hit  = 1'b1;
                4'hA:    dec.prg1_hit = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tbr_outmap.sv
module tbr_outmap
    import tbr_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int PRG_W  = 8
) (
    input  logic [SLOT_CNT-1:0][BANK_W-1:0] slot_in,
    input  logic                            outer,
    input  logic [PRG_W-1:0]                prg0,
    input  logic [PRG_W-1:0]                prg1,
    input  logic                            mir,
    output logic [SLOT_CNT-1:0][BANK_W:0]   slot_bank,
    output logic [PRG_WIN-1:0][PRG_W-1:0]   prg_page,
    output logic                            mirror_horiz
);

    localparam logic [PRG_W-1:0] PAGE_LAST = '1;
    localparam logic [PRG_W-1:0] PAGE_PREV = PAGE_LAST - PRG_W'(1);

    for (genvar g = 0; g < SLOT_CNT; g++) begin : g_slot
        assign slot_bank[g] = {outer, slot_in[g]};
    end

    assign prg_page[0]  = prg0;
    assign prg_page[1]  = prg1;
    assign prg_page[2]  = PAGE_PREV;
    assign prg_page[3]  = PAGE_LAST;
    assign mirror_horiz = mir;

endmodule

// File: rtl/tile_bank_regfile.sv
module tile_bank_regfile
    import tbr_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int PRG_W  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            en,
    input  logic                            wr_stb,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [DATA_W-1:0]               wr_data,
    input  logic                            outer_sel,
    output logic [SLOT_CNT-1:0][BANK_W:0]   slot_bank,
    output logic [PRG_WIN-1:0][PRG_W-1:0]   prg_page,
    output logic                            mirror_horiz
);

    localparam int NIB_W = BANK_W / 2;

    typedef struct packed {
        logic [SLOT_CNT-1:0][BANK_W-1:0] slot;
        logic [PRG_W-1:0]                prg0;
        logic [PRG_W-1:0]                prg1;
        logic                            mir;
        logic                            outer;
    } state_t;

    function automatic state_t reset_state();
        state_t s;
        s = '0;
        for (int i = 0; i < SLOT_CNT; i++) begin
            if (i < SLOT_CNT / 2) s.slot[i] = '1;
            else                  s.slot[i] = BANK_W'(i);
        end
        s.prg1 = PRG_W'(1);
        return s;
    endfunction

    localparam state_t RST_STATE = reset_state();

    wr_dec_t dec;
    state_t  st_d, st_q;

    tbr_decode #(.ADDR_W(ADDR_W)) i_dec (
        .addr (wr_addr),
        .dec  (dec)
    );

    always_comb begin
        st_d       = st_q;
        st_d.outer = outer_sel;
        if (en && wr_stb) begin
            if (dec.slot_hit) begin
                if (dec.hi_nib)
                    st_d.slot[dec.slot_idx][BANK_W-1:NIB_W] = wr_data[NIB_W-1:0];
                else
                    st_d.slot[dec.slot_idx][NIB_W-1:0] = wr_data[NIB_W-1:0];
            end
            if (dec.prg0_hit) st_d.prg0 = wr_data[PRG_W-1:0];
            if (dec.prg1_hit) st_d.prg1 = wr_data[PRG_W-1:0];
            if (dec.mir_hit)  st_d.mir  = wr_data[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_STATE;
        else        st_q <= st_d;
    end

    tbr_outmap #(.BANK_W(BANK_W), .PRG_W(PRG_W)) i_map (
        .slot_in      (st_q.slot),
        .outer        (st_q.outer),
        .prg0         (st_q.prg0),
        .prg1         (st_q.prg1),
        .mir          (st_q.mir),
        .slot_bank    (slot_bank),
        .prg_page     (prg_page),
        .mirror_horiz (mirror_horiz)
    );

endmodule

// File: rtl/tbr_checker.sv
module tbr_checker
    import tbr_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int PRG_W  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            en,
    input logic                            wr_stb,
    input logic [ADDR_W-1:0]               wr_addr,
    input logic [DATA_W-1:0]               wr_data,
    input logic                            outer_sel,
    input logic [SLOT_CNT-1:0][BANK_W:0]   slot_bank,
    input logic [PRG_WIN-1:0][PRG_W-1:0]   prg_page,
    input logic                            mirror_horiz
);

    localparam int NIB_W = BANK_W / 2;

    logic acc;
    assign acc = en && wr_stb;

    // R7: one cycle after reset is seen low, outputs show the reset values
    p_reset_vals_r7: assert property (@(posedge clk)
        !rst_n |=> (prg_page[0] == '0 && prg_page[1] == PRG_W'(1) &&
                    slot_bank[0][BANK_W-1:0] == '1 &&
                    slot_bank[SLOT_CNT-1][BANK_W-1:0] == BANK_W'(SLOT_CNT-1) &&
                    !mirror_horiz));

    // R8: without an accepted write, program and mirroring state hold
    p_hold_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> ($stable(prg_page[0]) && $stable(prg_page[1]) && $stable(mirror_horiz)));

    // R3: full-byte load of program page 0
    p_prg0_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && wr_addr[15:12] == 4'h8) |=> prg_page[0] == $past(wr_data[PRG_W-1:0]));

    // R3: full-byte load of program page 1
    p_prg1_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && wr_addr[15:12] == 4'hA) |=> prg_page[1] == $past(wr_data[PRG_W-1:0]));

    // R5: mirroring takes data bit 0
    p_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && wr_addr[15:12] == 4'h9) |=> mirror_horiz == $past(wr_data[0]));

    // R2: high-nibble write to slot 0 keeps the low nibble
    p_nibble_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && wr_addr == ADDR_W'('hB001)) |=>
            (slot_bank[0][BANK_W-1:NIB_W] == $past(wr_data[NIB_W-1:0]) &&
             slot_bank[0][NIB_W-1:0] == $past(slot_bank[0][NIB_W-1:0])));

    for (genvar g = 0; g < SLOT_CNT; g++) begin : g_slot_chk
        // R6: outer bit follows outer_sel one edge later
        p_outer_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> slot_bank[g][BANK_W] == $past(outer_sel));
        // R8: slot registers hold without an accepted write
        p_hold_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !acc |=> $stable(slot_bank[g][BANK_W-1:0]));
    end

endmodule

bind tile_bank_regfile tbr_checker #(
    .BANK_W(BANK_W), .PRG_W(PRG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) i_chk (.*);

// File: tb/test_tile_bank_regfile.sv
`timescale 1ns/1ps
module test_tile_bank_regfile;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0;
    logic              wr_stb = 1'b0;
    logic [15:0]       wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              outer_sel = 1'b0;
    logic [7:0][8:0]   slot_bank;
    logic [3:0][7:0]   prg_page;
    logic              mirror_horiz;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int ref_slot [8];
    int ref_prg0, ref_prg1, ref_mir, ref_outer;

    always #4 clk = ~clk;

    tile_bank_regfile i_tile_bank_regfile (
        .clk, .rst_n, .en, .wr_stb, .wr_addr, .wr_data, .outer_sel,
        .slot_bank, .prg_page, .mirror_horiz
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) ref_slot[i] = (i < 4) ? 'hFF : i;
        ref_prg0 = 0; ref_prg1 = 1; ref_mir = 0; ref_outer = 0;
    endtask

    // behavioural model of one clock edge
    task automatic model_edge(input bit e, input bit s, input int a, input int d, input bit o);
        int idx;
        ref_outer = o;
        if (e && s) begin
            if (a >= 'hB000 && a <= 'hE003) begin
                idx = ((((a & 2) | (a >> 10)) >> 1) + 2) % 8;
                if (a & 1) ref_slot[idx] = (ref_slot[idx] & 'h0F) | ((d & 'hF) << 4);
                else       ref_slot[idx] = (ref_slot[idx] & 'hF0) | (d & 'hF);
            end else begin
                case (a >> 12)
                    'h8: ref_prg0 = d;
                    'hA: ref_prg1 = d;
                    'h9: ref_mir  = d & 1;
                    default: ;
                endcase
            end
        end
    endtask

    task automatic compare_all(input string ctx);
        for (int i = 0; i < 8; i++)
            check(int'(slot_bank[i]) == ((ref_outer << 8) | ref_slot[i]),
                  $sformatf("R1 R2 R6 R10 slot%0d %s", i, ctx), int'(slot_bank[i]),
                  (ref_outer << 8) | ref_slot[i]);
        check(int'(prg_page[0]) == ref_prg0, {"R3 prg0 ", ctx}, int'(prg_page[0]), ref_prg0);
        check(int'(prg_page[1]) == ref_prg1, {"R3 prg1 ", ctx}, int'(prg_page[1]), ref_prg1);
        check(prg_page[2] == 8'hFE, {"R4 prg2 ", ctx}, int'(prg_page[2]), 'hFE);
        check(prg_page[3] == 8'hFF, {"R4 prg3 ", ctx}, int'(prg_page[3]), 'hFF);
        check(int'(mirror_horiz) == ref_mir, {"R5 mirror ", ctx}, int'(mirror_horiz), ref_mir);
    endtask

    // drive after a falling edge, model the rising edge, compare at the next falling edge
    task automatic step(input bit e, input bit s, input int a, input int d, input bit o, input string ctx);
        en = e; wr_stb = s; wr_addr = 16'(a); wr_data = 8'(d); outer_sel = o;
        @(posedge clk);
        model_edge(e, s, a, d, o);
        @(negedge clk);
        compare_all(ctx);
    endtask

    initial begin
        int addrs [16] = '{'hB000, 'hB001, 'hB002, 'hB003, 'hC000, 'hC001, 'hC002, 'hC003,
                           'hD000, 'hD001, 'hD002, 'hD003, 'hE000, 'hE001, 'hE002, 'hE003};
        model_reset();
        repeat (3) @(negedge clk);
        compare_all("R7 reset");
        rst_n = 1'b1;

        // R1 R2: every slot/nibble address, low then high nibble
        for (int k = 0; k < 16; k++) step(1, 1, addrs[k], 'hA0 + k, 0, "R1 R2 sweep");
        // R1: aliased in-range address folds onto slot 1
        step(1, 1, 'hB800, 'h03, 0, "R1 alias");
        // R3 R5
        step(1, 1, 'h8000, 'h5A, 0, "R3 prg0");
        step(1, 1, 'hAFFF, 'hFF, 0, "R3 prg1");
        step(1, 1, 'h9000, 'h01, 0, "R5 horiz");
        step(1, 1, 'h9123, 'hFE, 0, "R5 vert");
        // R9: value not visible before the sampling edge
        en = 1; wr_stb = 1; wr_addr = 16'h8000; wr_data = 8'h33; outer_sel = 0;
        #1;
        check(prg_page[0] == 8'h5A, "R9 before edge", int'(prg_page[0]), 'h5A);
        @(posedge clk); model_edge(1, 1, 'h8000, 'h33, 0); @(negedge clk);
        compare_all("R9 after edge");
        // R8: gated writes
        step(0, 1, 'hB000, 'h07, 0, "R8 en low");
        step(1, 0, 'h8000, 'h11, 0, "R8 stb low");
        step(0, 1, 'h9000, 'h00, 0, "R8 en low mirror");
        // R10: out-of-window addresses
        step(1, 1, 'hE004, 'h09, 0, "R10 E004");
        step(1, 1, 'hF000, 'h09, 0, "R10 F000");
        step(1, 1, 'h7000, 'h09, 0, "R10 7000");
        step(1, 1, 'h0000, 'h09, 0, "R10 0000");
        // R6: outer bit toggles
        step(0, 0, 0, 0, 1, "R6 outer on");
        step(1, 1, 'hD003, 'h0C, 1, "R6 outer write");
        step(0, 0, 0, 0, 0, "R6 outer off");
        // randomized mix
        for (int n = 0; n < 400; n++) begin
            int a;
            int sel = $urandom_range(0, 3);
            if (sel == 0)      a = addrs[$urandom_range(0, 15)];
            else if (sel == 1) a = 'h8000 + ($urandom_range(0, 2) << 12) + $urandom_range(0, 'hFFF);
            else               a = $urandom_range(0, 'hFFFF);
            step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) != 0), a,
                 $urandom_range(0, 255), 1'($urandom_range(0, 1)), "random");
        end
        // R7: reset again mid-run
        @(negedge clk); rst_n = 1'b0; model_reset();
        @(negedge clk); compare_all("R7 reset again");
        rst_n = 1'b1;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule